// File: doc/BRIEF.md
# Byte LIFO Stack with Status Display

This block is a last-in, first-out store of byte-wide entries held in a register array and addressed by one pointer. A push writes the input byte at the slot the pointer names, then advances the pointer. A pop first steps the pointer back, then returns the entry found at the new address. The pointer is one bit wider than the address, so an empty stack and a stack with every slot used are different pointer values. Push and pop are clean single-cycle strobes from the surrounding logic. A synchronous reset returns the stack to empty.

The block raises three status flags: empty, full and a sticky overflow. A push attempted while full sets the overflow flag. The same status drives a four-digit multiplexed seven-segment display that spells it out in letters. The digits are refreshed in turn from a free-running counter, with one digit enable active at a time.

Top module: `lifo_stack_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `empty`=1, `full`=0, `overflow`=0, `pop_data`=0 and `an_n`=4'b1110.
- R2: A push with the stack not full stores `din` on top and grows the occupancy by one. A pop with the stack not empty returns the most recently pushed entry still held, in the cycle after the pop strobe, and shrinks the occupancy by one.
- R3: `pop_data` changes only on an executed pop. Pushes, ignored pops and idle cycles leave it unchanged.
- R4: `empty` is 1 exactly when the occupancy is 0. `full` is 1 exactly when the occupancy equals DEPTH (32 by default).
- R5: A push while full sets `overflow` in the next cycle and leaves the stored entries and occupancy unchanged.
- R6: Once set, `overflow` stays 1 through any push or pop until reset.
- R7: A pop while empty is ignored. The stack stays empty, `pop_data` is unchanged and the pointer does not wrap, so a following push and pop behave as on a fresh stack.
- R8: When push and pop are strobed in the same cycle, the push is carried out and the pop is ignored.
- R9: Exactly one bit of `an_n` is low. The active digit index is bits [SCAN_W-1:SCAN_W-2] of a counter that clears on reset and increments every cycle, so digits 0,1,2,3 are each held for 2^(SCAN_W-2) cycles.
- R10: `seg_n` is active low, with bit 0 = segment a up to bit 6 = segment g. The shown glyph depends on the active digit and the status. With overflow set, digits 2,1,0 show O (7'h40), V (7'h41) and F (7'h0E), and digit 3 is blank (7'h7F). Otherwise, when full, digit 0 shows F (7'h0E). Otherwise, when empty, digit 0 shows E (7'h06). Every other digit is blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | One-cycle push strobe |
| pop | input | 1 | One-cycle pop strobe |
| din | input | DW | Byte to push |
| pop_data | output | DW | Entry returned by the latest executed pop |
| empty | output | 1 | No entries held |
| full | output | 1 | All DEPTH entries held |
| overflow | output | 1 | Sticky push-while-full indication |
| an_n | output | 4 | Digit enables, active low |
| seg_n | output | 7 | Segments a..g, active low |

## Verification
A corrupted pointer shows up one cycle later as a wrong `empty` or `full` flag, or as a pop that returns an entry out of order. A pointer that wraps on pop-while-empty shows up as a false `full` or a stale value on the next pop. A lost or spuriously set overflow bit changes the letters on the display at once. A stuck scan counter breaks the digit rotation within 2^(SCAN_W-2) cycles. The bench keeps its own model of the stack and display, and compares every output after every cycle of directed and random push and pop traffic.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

   typedef enum logic [2:0] {
      GL_BLANK,
      GL_E,
      GL_F,
      GL_O,
      GL_V
   } glyph_e;

   // Active-high segment pattern, bit 0 = segment a .. bit 6 = segment g
   function automatic logic [6:0] glyph_seg(input glyph_e g);
      logic [6:0] s;
      case (g)
         GL_E:    s = 7'b1111001;
         GL_F:    s = 7'b1110001;
         GL_O:    s = 7'b0111111;
         GL_V:    s = 7'b0111110;
         default: s = 7'b0000000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lifo_flags.sv
module lifo_flags #(
   parameter int DEPTH = 32,
   parameter int PW    = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [PW-1:0] ptr,
   output logic          empty,
   output logic          full,
   output logic          overflow,
   output logic          push_en,
   output logic          pop_en
);
   localparam logic [PW-1:0] PTR_FULL = PW'(DEPTH);

   always_comb begin
      empty   = (ptr == '0);
      full    = (ptr == PTR_FULL);
      push_en = push && !full;
      pop_en  = pop && !push && !empty;
   end

   always_ff @(posedge clk) begin
      if (rst)
         overflow <= 1'b0;
      else if (push && full)
         overflow <= 1'b1;
   end
endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   parameter int AW    = 5,
   parameter int PW    = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push_en,
   input  logic          pop_en,
   input  logic [DW-1:0] din,
   output logic [PW-1:0] ptr,
   output logic [DW-1:0] pop_data
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] ptr_dec;

   assign ptr_dec = ptr - PW'(1);

   always_ff @(posedge clk) begin
      if (push_en)
         mem[ptr[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr      <= '0;
         pop_data <= '0;
      end else if (push_en) begin
         ptr <= ptr + PW'(1);
      end else if (pop_en) begin
         ptr      <= ptr_dec;
         pop_data <= mem[ptr_dec[AW-1:0]];
      end
   end
endmodule

// File: rtl/lifo_seg_scan.sv
module lifo_seg_scan
   import lifo_pkg::*;
#(
   parameter int SCAN_W         = 16,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       empty,
   input  logic       full,
   input  logic       overflow,
   output logic [3:0] an_n,
   output logic [6:0] seg_n
);
   logic [SCAN_W-1:0] scan_cnt;
   logic [1:0]        dig;
   glyph_e            glyph;
   logic [6:0]        seg_hi;

   always_ff @(posedge clk) begin
      if (rst) scan_cnt <= '0;
      else     scan_cnt <= scan_cnt + SCAN_W'(1);
   end

   assign dig  = scan_cnt[SCAN_W-1 -: 2];
   assign an_n = ~(4'b0001 << dig);

   always_comb begin
      glyph = GL_BLANK;
      if (overflow) begin
         case (dig)
            2'd2:    glyph = GL_O;
            2'd1:    glyph = GL_V;
            2'd0:    glyph = GL_F;
            default: glyph = GL_BLANK;
         endcase
      end else if (dig == 2'd0) begin
         if (full)       glyph = GL_F;
         else if (empty) glyph = GL_E;
      end
   end

   assign seg_hi = glyph_seg(glyph);

   generate
      if (SEG_ACTIVE_LOW) begin : g_seg_low
         assign seg_n = ~seg_hi;
      end else begin : g_seg_high
         assign seg_n = seg_hi;
      end
   endgenerate
endmodule

// File: rtl/lifo_stack_top.sv
module lifo_stack_top #(
   parameter int DEPTH          = 32,
   parameter int DW             = 8,
   parameter int SCAN_W         = 16,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] pop_data,
   output logic          empty,
   output logic          full,
   output logic          overflow,
   output logic [3:0]    an_n,
   output logic [6:0]    seg_n
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("lifo_stack_top: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("lifo_stack_top: DW must be at least 1");
      end
      if (SCAN_W < 2) begin : g_bad_scan
         $error("lifo_stack_top: SCAN_W must be at least 2");
      end
   endgenerate

   logic [PW-1:0] ptr;
   logic          push_en;
   logic          pop_en;

   lifo_flags #(.DEPTH(DEPTH), .PW(PW)) u_flags (
      .clk(clk), .rst(rst), .push(push), .pop(pop), .ptr(ptr),
      .empty(empty), .full(full), .overflow(overflow),
      .push_en(push_en), .pop_en(pop_en)
   );

   lifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_store (
      .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
      .din(din), .ptr(ptr), .pop_data(pop_data)
   );

   lifo_seg_scan #(.SCAN_W(SCAN_W), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)) u_scan (
      .clk(clk), .rst(rst), .empty(empty), .full(full), .overflow(overflow),
      .an_n(an_n), .seg_n(seg_n)
   );
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          push,
   input logic          pop,
   input logic [DW-1:0] pop_data,
   input logic          empty,
   input logic          full,
   input logic          overflow,
   input logic [3:0]    an_n
);
   // R4
   both_flags_chk: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));

   // R2
   push_fill_chk: assert property (@(posedge clk) disable iff (rst)
      push && !full |=> !empty);

   // R3
   hold_data_chk: assert property (@(posedge clk) disable iff (rst)
      !pop |=> $stable(pop_data));

   // R5
   push_full_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      push && full |=> overflow && full);

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   // R7
   pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
      pop && !push && empty |=> empty && $stable(pop_data));

   // R8
   push_pop_chk: assert property (@(posedge clk) disable iff (rst)
      push && pop && !full |=> !empty && $stable(pop_data));

   // R9
   one_anode_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(~an_n) == 1);
endmodule

bind lifo_stack_top lifo_stack_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst(rst), .push(push), .pop(pop), .pop_data(pop_data),
   .empty(empty), .full(full), .overflow(overflow), .an_n(an_n)
);

// File: tb/lifo_stack_top_bench.sv
`timescale 1ns/1ps
module lifo_stack_top_bench;
   localparam int DEPTH  = 32;
   localparam int DW     = 8;
   localparam int SCAN_W = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          push = 1'b0;
   logic          pop = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] pop_data;
   logic          empty, full, overflow;
   logic [3:0]    an_n;
   logic [6:0]    seg_n;

   lifo_stack_top #(.DEPTH(DEPTH), .DW(DW), .SCAN_W(SCAN_W)) u_lifo_stack_top (
      .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
      .pop_data(pop_data), .empty(empty), .full(full), .overflow(overflow),
      .an_n(an_n), .seg_n(seg_n)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // model state
   logic [DW-1:0] m_mem [DEPTH];
   int            m_cnt = 0;
   bit            m_ovf = 1'b0;
   logic [DW-1:0] m_pop = '0;
   int unsigned   cyc = 0;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] exp_seg(input int d, input bit e, input bit f, input bit o);
      if (o) begin
         case (d)
            2: return 7'h40;
            1: return 7'h41;
            0: return 7'h0E;
            default: return 7'h7F;
         endcase
      end
      if (d == 0 && f) return 7'h0E;
      if (d == 0 && e) return 7'h06;
      return 7'h7F;
   endfunction

   task automatic check_all();
      int d;
      d = int'((cyc >> (SCAN_W - 2)) & 3);
      check(pop_data == m_pop, "R2 R3 pop_data", pop_data, m_pop);
      check(empty == (m_cnt == 0), "R4 empty", empty, m_cnt == 0);
      check(full == (m_cnt == DEPTH), "R4 full", full, m_cnt == DEPTH);
      check(overflow == m_ovf, "R5 R6 overflow", overflow, m_ovf);
      check(an_n == ~(4'b0001 << d), "R9 anodes", an_n, ~(4'b0001 << d));
      check(seg_n == exp_seg(d, m_cnt == 0, m_cnt == DEPTH, m_ovf),
            "R10 segments", seg_n, exp_seg(d, m_cnt == 0, m_cnt == DEPTH, m_ovf));
   endtask

   task automatic op(input bit pu, input bit po, input logic [DW-1:0] d);
      push = pu; pop = po; din = d;
      @(posedge clk);
      if (pu) begin
         if (m_cnt == DEPTH) m_ovf = 1'b1;
         else begin m_mem[m_cnt] = d; m_cnt++; end
      end else if (po && m_cnt > 0) begin
         m_cnt--;
         m_pop = m_mem[m_cnt];
      end
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
      check_all();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_cnt = 0; m_ovf = 1'b0; m_pop = '0;
      // R1: reset state seen at the ports
      check(empty && !full && !overflow, "R1 flags", {empty, full, overflow}, 3'b100);
      check(pop_data == '0, "R1 pop_data", pop_data, 0);
      check(an_n == 4'b1110, "R1 anodes", an_n, 4'b1110);
      check_all();
   endtask

   initial begin
      void'($urandom(32'd1234));
      do_reset();

      // R7: pop on empty is ignored, no wrap
      op(1'b0, 1'b1, 8'h00);
      check(empty && !full, "R7 pop on empty", {empty, full}, 2'b10);
      op(1'b1, 1'b0, 8'hA5);
      op(1'b0, 1'b1, 8'h00);
      check(pop_data == 8'hA5, "R7 R2 push pop after empty pop", pop_data, 8'hA5);

      // R4: fill to full
      for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, 8'(i * 7 + 3));
      check(full, "R4 full after DEPTH pushes", full, 1);
      // R5: push while full
      op(1'b1, 1'b0, 8'hEE);
      check(overflow && full, "R5 overflow on push full", {overflow, full}, 2'b11);
      // R2 R5: drain in reverse, contents untouched
      for (int i = DEPTH - 1; i >= 0; i--) begin
         op(1'b0, 1'b1, 8'h00);
         check(pop_data == 8'(i * 7 + 3), "R2 R5 LIFO order", pop_data, 8'(i * 7 + 3));
      end
      // R6: overflow survives drain and empty pop
      op(1'b0, 1'b1, 8'h00);
      check(overflow && empty, "R6 R7 sticky overflow", {overflow, empty}, 2'b11);
      // R8: push and pop together
      op(1'b1, 1'b1, 8'h3C);
      check(!empty, "R8 push wins", empty, 0);
      op(1'b0, 1'b1, 8'h00);
      check(pop_data == 8'h3C, "R8 pushed value", pop_data, 8'h3C);
      repeat (10) op(1'b0, 1'b0, 8'h00);

      // random phases with push bias alternating
      for (int ph = 0; ph < 6; ph++) begin
         int bias;
         do_reset();
         bias = (ph % 2 == 0) ? 75 : 30;
         for (int k = 0; k < 150; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < bias)       op(1'b1, 1'b0, 8'($urandom));
            else if (r < 94)    op(1'b0, 1'b1, 8'($urandom));
            else if (r < 97)    op(1'b1, 1'b1, 8'($urandom));
            else                op(1'b0, 1'b0, 8'($urandom));
         end
      end

      do_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule